// File: doc/BRIEF.md
# SD Video Scrambler with 11x Bit Replication

This block prepares a standard-definition serial video stream for a transceiver whose line rate is fixed at eleven times the SD bit rate. It accepts 10-bit video words, one per input strobe (nominally 27 MHz, in the fast clock domain). It passes the bits least significant first through a self-synchronizing scrambler and an NRZI encoder. It then repeats every resulting bit eleven times and packs the repeated stream into 20-bit parallel words. Because each serial bit occupies eleven line-rate slots, the fixed high-rate serializer emits a valid low-rate bitstream.

One input word becomes 110 output bits, which is 5.5 output words. A gearbox holds the bits that are not yet sent, emits one 20-bit word on every fast-clock cycle in which at least 20 bits are pending, and carries the leftover half word into the next input word. Nothing in the logic depends on the absolute clock frequency, so the same datapath serves both the integer rates and the rates divided by 1.001. A word that arrives while the gearbox is too full is discarded, and an overflow flag is raised.

Top module: `sdos_replicator`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears the scrambler history, the NRZI state and the gearbox fill. After reset, `out_strobe_o` and `ovf_o` read 0, and the next stream is encoded as if all previous scrambled bits and the NRZI level were 0.
- R2: Scrambled bit s(n) equals d(n) XOR s(n-4) XOR s(n-9), with input bits taken from `in_data_i` bit 0 upward (least significant first). The generator is x^9 + x^4 + 1.
- R3: Output line bit t(n) equals s(n) XOR t(n-1) (NRZI, x + 1).
- R4: Every encoded bit t(n) appears in 11 consecutive slots of the output stream. Within `out_word_o`, bit 0 is the earliest slot, and successive strobed words continue the stream without gaps.
- R5: A word accepted at a clock edge produces its first strobed output word at the following edge. `out_strobe_o` is high in exactly those cycles that emit a 20-bit word while 20 or more bits are pending. A single word after reset gives exactly 5 strobes, and the remaining 10 bits are held.
- R6: The gearbox carries residues across input words, so two accepted words always yield 11 output words (220 bits) with no bit lost or duplicated.
- R7: If `in_valid_i` is high at an edge where the bits still pending after that edge's output word exceed 20, the word is discarded. The scrambler state does not change, and `ovf_o` is high for that one following cycle.
- R8: For any input spacing that does not overflow (for example alternating 5 and 6 cycles, or long idle gaps), the output bitstream depends only on the accepted data sequence and not on the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock; one output word per cycle at most |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Input word strobe (SD word rate) |
| in_data_i | input | 10 | SD video word, bit 0 sent first |
| out_word_o | output | 20 | Replicated line bits, bit 0 sent first |
| out_strobe_o | output | 1 | High when out_word_o carries a new word |
| ovf_o | output | 1 | One-cycle pulse: last input word was discarded |

## Verification
The bench reassembles the strobed words into one bitstream. It checks that every group of eleven slots is uniform and that the group values match an independently computed scrambler and NRZI model. A design that swapped the tap order, shifted bits most significant first or replicated ten or twelve times would break that match. Spacings of 5 and 6 cycles and long gaps exercise the half-word residue, which a gearbox that drops or repeats the leftover ten bits would get wrong in the total word count. Directed cases hit the overflow threshold exactly one cycle early (a design that kept the dropped word would misalign the later stream), a lone word's five-strobe pattern, and a reset in mid-stream that must restart the scrambler from zero.

// File: rtl/sdos_pkg.sv
package sdos_pkg;
   localparam int unsigned SD_WORD_W = 10;
   localparam int unsigned LINE_REP  = 11;
   localparam int unsigned LINE_W    = 20;
   localparam int unsigned SCR_LEN   = 9;
   localparam int unsigned SCR_TAP   = 4;

   typedef struct packed {
      logic [SCR_LEN-1:0] hist;   // hist[0] = most recent scrambled bit
      logic               level;  // NRZI line level
   } scr_state_t;
endpackage

// File: rtl/sdos_scrambler.sv
module sdos_scrambler
   import sdos_pkg::*;
#(
   parameter int unsigned IN_W = SD_WORD_W
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            take,
   input  logic [IN_W-1:0] din,
   output logic [IN_W-1:0] dout
);
   scr_state_t st_q, st_d;

   always_comb begin
      logic [SCR_LEN-1:0] h;
      logic               lv;
      logic               s;
      h    = st_q.hist;
      lv   = st_q.level;
      dout = '0;
      for (int i = 0; i < IN_W; i++) begin
         s       = din[i] ^ h[SCR_TAP-1] ^ h[SCR_LEN-1];
         h       = {h[SCR_LEN-2:0], s};
         lv      = lv ^ s;
         dout[i] = lv;
      end
      st_d.hist  = h;
      st_d.level = lv;
   end

   always_ff @(posedge clk) begin
      if (rst)       st_q <= '0;
      else if (take) st_q <= st_d;
   end
endmodule

// File: rtl/sdos_expand.sv
module sdos_expand #(
   parameter int unsigned IN_W = 10,
   parameter int unsigned REP  = 11,
   localparam int unsigned EXP_W = IN_W * REP
) (
   input  logic [IN_W-1:0]  bits,
   output logic [EXP_W-1:0] expanded
);
   for (genvar i = 0; i < IN_W; i++) begin : g_bit
      assign expanded[i*REP +: REP] = {REP{bits[i]}};
   end
endmodule

// File: rtl/sdos_gearbox.sv
module sdos_gearbox #(
   parameter int unsigned IN_BITS = 110,
   parameter int unsigned OUT_W   = 20,
   localparam int unsigned BUF_W  = IN_BITS + OUT_W,
   localparam int unsigned FILL_W = $clog2(BUF_W + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [IN_BITS-1:0] in_bits,
   output logic               take,
   output logic [FILL_W-1:0]  fill,
   output logic [OUT_W-1:0]   word,
   output logic               strobe,
   output logic               ovf
);
   logic [BUF_W-1:0]  buf_q, rem_buf, nxt_buf;
   logic [FILL_W-1:0] fill_q, rem_fill, nxt_fill;
   logic              emit, ovf_now;

   always_comb begin
      emit     = fill_q >= FILL_W'(OUT_W);
      rem_fill = emit ? fill_q - FILL_W'(OUT_W) : fill_q;
      rem_buf  = emit ? (buf_q >> OUT_W) : buf_q;
      ovf_now  = in_valid && (rem_fill > FILL_W'(OUT_W));
      take     = in_valid && !ovf_now;
      nxt_buf  = rem_buf;
      nxt_fill = rem_fill;
      if (take) begin
         nxt_buf  = rem_buf | (BUF_W'(in_bits) << rem_fill);
         nxt_fill = rem_fill + FILL_W'(IN_BITS);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_q  <= '0;
         fill_q <= '0;
         word   <= '0;
         strobe <= 1'b0;
         ovf    <= 1'b0;
      end else begin
         buf_q  <= nxt_buf;
         fill_q <= nxt_fill;
         strobe <= emit;
         ovf    <= ovf_now;
         if (emit) word <= buf_q[OUT_W-1:0];
      end
   end

   assign fill = fill_q;
endmodule

// File: rtl/sdos_replicator.sv
module sdos_replicator
   import sdos_pkg::*;
#(
   parameter int unsigned IN_W  = SD_WORD_W,
   parameter int unsigned REP   = LINE_REP,
   parameter int unsigned OUT_W = LINE_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             in_valid_i,
   input  logic [IN_W-1:0]  in_data_i,
   output logic [OUT_W-1:0] out_word_o,
   output logic             out_strobe_o,
   output logic             ovf_o
);
   localparam int unsigned EXP_W  = IN_W * REP;
   localparam int unsigned FILL_W = $clog2(EXP_W + OUT_W + 1);

   if (REP < 1 || OUT_W < 1 || OUT_W > EXP_W) begin : g_bad_cfg
      $error("sdos_replicator: OUT_W must lie in 1..IN_W*REP");
   end
   if (IN_W < 1) begin : g_bad_in
      $error("sdos_replicator: IN_W must be at least 1");
   end

   logic [IN_W-1:0]   scr_bits;
   logic [EXP_W-1:0]  exp_bits;
   logic              take_w;
   logic [FILL_W-1:0] fill_w;

   sdos_scrambler #(.IN_W(IN_W)) u_scr (
      .clk (clk_i), .rst (rst_i), .take (take_w),
      .din (in_data_i), .dout (scr_bits)
   );

   sdos_expand #(.IN_W(IN_W), .REP(REP)) u_exp (
      .bits (scr_bits), .expanded (exp_bits)
   );

   sdos_gearbox #(.IN_BITS(EXP_W), .OUT_W(OUT_W)) u_gbx (
      .clk (clk_i), .rst (rst_i), .in_valid (in_valid_i),
      .in_bits (exp_bits), .take (take_w), .fill (fill_w),
      .word (out_word_o), .strobe (out_strobe_o), .ovf (ovf_o)
   );
endmodule

// File: rtl/sdos_chk.sv
module sdos_chk #(
   parameter int unsigned EXP_W  = 110,
   parameter int unsigned OUT_W  = 20,
   parameter int unsigned FILL_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [FILL_W-1:0] fill,
   input logic              out_strobe,
   input logic              ovf
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!out_strobe && !ovf && fill == '0));

   // R5
   strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
      out_strobe |-> ($past(fill) >= FILL_W'(OUT_W)));

   // R5
   no_strobe_miss_chk: assert property (@(posedge clk) disable iff (rst)
      (fill >= FILL_W'(OUT_W)) |=> out_strobe);

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
      ovf |-> ($past(in_valid) && $past(fill) > FILL_W'(2*OUT_W)));

   // R7
   ovf_drop_chk: assert property (@(posedge clk) disable iff (rst)
      ovf |-> (fill == $past(fill) - FILL_W'(OUT_W)));

   // R6
   fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
      fill <= FILL_W'(EXP_W + OUT_W));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && fill < FILL_W'(OUT_W)) |=> $stable(fill));
endmodule

bind sdos_replicator sdos_chk #(
   .EXP_W(EXP_W), .OUT_W(OUT_W), .FILL_W(FILL_W)
) u_chk (
   .clk (clk_i), .rst (rst_i), .in_valid (in_valid_i),
   .fill (fill_w), .out_strobe (out_strobe_o), .ovf (ovf_o)
);

// File: tb/tb_sdos_replicator.sv
module tb_sdos_replicator;
   localparam int IW = 10, RP = 11, OW = 20;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [IW-1:0] in_data = '0;
   logic [OW-1:0] out_word;
   logic          out_strobe, ovf;

   int errors = 0, checks = 0;

   always #4 clk = ~clk;

   sdos_replicator dut (
      .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_data_i(in_data),
      .out_word_o(out_word), .out_strobe_o(out_strobe), .ovf_o(ovf)
   );

   // stream capture
   bit cap [0:8191];
   int cap_n = 0;
   always @(negedge clk) begin
      if (out_strobe) begin
         for (int k = 0; k < OW; k++) cap[cap_n + k] = out_word[k];
         cap_n += OW;
      end
   end

   // reference scrambler and NRZI model
   bit s_hist [0:1023];
   bit ref_b  [0:1023];
   int ref_n = 0;
   bit ref_lvl = 0;

   task automatic model_clear();
      ref_n = 0; ref_lvl = 0; cap_n = 0;
   endtask

   task automatic model_word(input logic [IW-1:0] w);
      for (int b = 0; b < IW; b++) begin
         bit s;
         s = w[b];
         if (ref_n >= 4) s = s ^ s_hist[ref_n-4];
         if (ref_n >= 9) s = s ^ s_hist[ref_n-9];
         s_hist[ref_n] = s;
         ref_lvl = ref_lvl ^ s;
         ref_b[ref_n] = ref_lvl;
         ref_n++;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   task automatic send(input logic [IW-1:0] w, input int gap, input bit exp_ovf);
      @(negedge clk);
      in_valid = 1'b1; in_data = w;
      @(negedge clk);
      in_valid = 1'b0;
      check(ovf == exp_ovf, "R7", "overflow flag", int'(ovf), int'(exp_ovf));
      if (!exp_ovf) model_word(w);
      repeat (gap - 1) @(posedge clk);
   endtask

   // compare captured stream against model: full 11-slot groups only
   task automatic verify(input string req, input int exp_words);
      check(cap_n == exp_words * OW, "R6", {req, " output bit count"},
            cap_n, exp_words * OW);
      for (int w = 0; w * IW < ref_n; w++) begin
         logic [IW-1:0] got, want;
         int bad;
         got = '0; want = '0; bad = 0;
         for (int b = 0; b < IW; b++) begin
            int j;
            j = w * IW + b;
            want[b] = ref_b[j];
            if (j * RP + RP - 1 < cap_n) begin
               got[b] = cap[j * RP + RP / 2];
               for (int k = 0; k < RP; k++)
                  if (cap[j * RP + k] != ref_b[j]) bad++;
            end else begin
               got[b] = ref_b[j];
            end
         end
         check(bad == 0, req, "R2/R3/R4 encoded word", int'(got), int'(want));
      end
   endtask

   // stimulus table: {gap[5:0], data[9:0]}, no entry overflows
   localparam logic [15:0] VEC [16] = '{
      {6'd5,  10'h3FF}, {6'd6,  10'h000}, {6'd5,  10'h200}, {6'd6,  10'h3FC},
      {6'd5,  10'h001}, {6'd6,  10'h2AA}, {6'd9,  10'h155}, {6'd5,  10'h040},
      {6'd6,  10'h3B7}, {6'd12, 10'h0F0}, {6'd5,  10'h1E3}, {6'd6,  10'h2C8},
      {6'd5,  10'h010}, {6'd6,  10'h37A}, {6'd7,  10'h101}, {6'd20, 10'h0AB}
   };

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state at the ports
      do_reset();
      check(out_strobe == 1'b0, "R1", "strobe after reset", int'(out_strobe), 0);
      check(ovf == 1'b0, "R1", "ovf after reset", int'(ovf), 0);

      // R5: lone word gives 5 strobes, first one cycle after acceptance
      @(negedge clk);
      in_valid = 1'b1; in_data = 10'h2A5;
      @(negedge clk);
      in_valid = 1'b0;
      model_word(10'h2A5);
      check(out_strobe == 1'b0, "R5", "strobe in accept cycle", int'(out_strobe), 0);
      for (int i = 1; i <= 7; i++) begin
         @(negedge clk);
         check(out_strobe == (i <= 5), "R5", $sformatf("strobe cycle %0d", i),
               int'(out_strobe), int'(i <= 5));
      end
      verify("R5", 5);

      // R6/R2/R3/R4: table walk with alternating spacing
      do_reset();
      foreach (VEC[i]) send(VEC[i][9:0], int'(VEC[i][15:10]), 1'b0);
      repeat (10) @(posedge clk);
      @(negedge clk);
      verify("R6", 88);

      // R8: same data, wide spacing, must give the same stream
      do_reset();
      foreach (VEC[i]) send(VEC[i][9:0], 30, 1'b0);
      repeat (10) @(posedge clk);
      @(negedge clk);
      verify("R8", 88);

      // R7: word arriving one cycle too early is dropped
      do_reset();
      send(10'h1C7, 4, 1'b0);
      send(10'h3E1, 5, 1'b1);
      check(ovf == 1'b0, "R7", "ovf is a single pulse", int'(ovf), 0);
      send(10'h05A, 8, 1'b0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      verify("R7", 11);

      // R7 boundary: three 5-cycle gaps overflow only on the fourth word
      do_reset();
      send(10'h111, 5, 1'b0);
      send(10'h222, 5, 1'b0);
      send(10'h333, 5, 1'b0);
      send(10'h0CC, 6, 1'b1);
      repeat (10) @(posedge clk);
      @(negedge clk);
      verify("R7", 16);

      // R1: reset in mid-stream restarts scrambler and gearbox
      do_reset();
      send(10'h3A3, 3, 1'b0);
      do_reset();
      send(10'h155, 8, 1'b0);
      @(negedge clk);
      verify("R1", 5);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule